// File: doc/BRIEF.md
# Two-Slot CAS Latency Selector

This block settles the CAS latency for a memory controller that serves two DRAM module slots. Each slot presents its supported-latency bitmap and two encoded cycle-time bytes. These bytes give the shortest clock period the module tolerates at one and at two steps below its slowest supported latency. The block also takes the current bus speed in MHz. When the start strobe arrives, it captures all inputs. It turns each cycle-time byte into a frequency with a sequential restoring divider and checks that frequency against the bus speed. It narrows each slot's bitmap to the latencies that remain legal, merges the two slots, and reports a 3-bit latency code.

The three outputs are a one-cycle done pulse, an error flag for modules with no latency in common, and the code. Firmware or a boot sequencer raises start once the module data has been gathered, then waits for done. The code and error flag keep their values until the next run finishes.

Top module: `cas_latency_sel`

## Requirements
- R1: After synchronous reset, done_o, err_o and lat_code_o are all 0.
- R2: A slot whose bitmap equals 0xFF is empty. Its narrowed map is 0, so the result is taken from the other slot alone.
- R3: A cycle-time byte b passes when b is nonzero and 20000 / (b[7:4]*10 + b[3:0]) is at least bus_mhz_i, using integer division. A zero byte fails.
- R4: A slot's step count starts at 0. It becomes 1 if the first cycle-time byte passes. The second byte is checked only when the first passed, and it raises the count to 2 if it passes too.
- R5: With h the index of the highest set bit of the bitmap and s the step count, the narrowed map is bitmap AND (0xFF << (h - s)), kept to 8 bits. When h < s, the shift amount is 0.
- R6: If narrowed map 0 is zero, map 1 is chosen. Otherwise, if map 1 is zero, map 0 is chosen. Otherwise their AND is chosen. When that AND is zero, err_o is 1 and lat_code_o is 0.
- R7: The index i of the lowest set bit of the chosen map picks lat_code_o from the table 0→5, 1→5, 2→2, 3→6, 4→3, 5→7, 6→4, 7→0. A chosen map of zero gives code 0, so two empty slots give code 0 with err_o at 0.
- R8: done_o is high for exactly one cycle at the end of each run. lat_code_o and err_o change only in that cycle and hold until the next run completes.
- R9: A start_i pulse that arrives while a run is in progress is ignored. The result is that of the run already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Capture inputs and begin a run (accepted only when idle) |
| slot0_map_i | input | 8 | Slot 0 supported-latency bitmap, 0xFF when empty |
| slot0_tck1_i | input | 8 | Slot 0 minimum cycle time, one step below slowest latency |
| slot0_tck2_i | input | 8 | Slot 0 minimum cycle time, two steps below slowest latency |
| slot1_map_i | input | 8 | Slot 1 supported-latency bitmap, 0xFF when empty |
| slot1_tck1_i | input | 8 | Slot 1 minimum cycle time, one step below slowest latency |
| slot1_tck2_i | input | 8 | Slot 1 minimum cycle time, two steps below slowest latency |
| bus_mhz_i | input | 10 | Bus speed in MHz |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | No common latency between the slots |
| lat_code_o | output | 3 | Selected latency code |

## Verification
A run lasts a variable number of cycles, because each cycle-time check that is not skipped costs one full divider pass. The bench therefore does not predict a fixed latency. It counts cycles after the start strobe until done_o is seen high and bounds that count. It samples lat_code_o and err_o on the falling edge of the done cycle, since that is when they first take their new values. On the following falling edge it confirms that done_o has dropped and that both results are unchanged.

// File: rtl/cas_sel_pkg.sv
package cas_sel_pkg;

    localparam int MAP_W  = 8;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREP,
        ST_WAIT,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic [MAP_W-1:0] map;
        logic [7:0]       tck1;
        logic [7:0]       tck2;
    } slot_cfg_t;

    // whole ns in upper nibble, tenths in lower nibble -> period in 0.1 ns
    function automatic logic [7:0] tck_divisor(input logic [7:0] b);
        return 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
    endfunction

    function automatic logic [2:0] hi_bit(input logic [MAP_W-1:0] m);
        logic [2:0] r;
        r = 3'd0;
        for (int i = 0; i < MAP_W; i++)
            if (m[i]) r = 3'(i);
        return r;
    endfunction

    // zero map reports index 7, which selects the "none" code
    function automatic logic [2:0] lo_bit(input logic [MAP_W-1:0] m);
        logic [2:0] r;
        r = 3'd7;
        for (int i = MAP_W - 1; i >= 0; i--)
            if (m[i]) r = 3'(i);
        return r;
    endfunction

    function automatic logic [MAP_W-1:0] trim_map(input logic [MAP_W-1:0] m,
                                                  input logic [1:0]       sh);
        logic [2:0] h;
        logic [2:0] amt;
        if (m == 8'hFF) return '0;
        h   = hi_bit(m);
        amt = (h >= 3'(sh)) ? h - 3'(sh) : 3'd0;
        return m & (8'hFF << amt);
    endfunction

    function automatic logic [CODE_W-1:0] cas_code(input logic [2:0] idx);
        case (idx)
            3'd0, 3'd1: return 3'd5;
            3'd2:       return 3'd2;
            3'd3:       return 3'd6;
            3'd4:       return 3'd3;
            3'd5:       return 3'd7;
            3'd6:       return 3'd4;
            default:    return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/cas_divider.sv
module cas_divider #(
    parameter int          NUM_W     = 15,
    parameter int          DEN_W     = 8,
    parameter int unsigned NUMERATOR = 20000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem_q, den_q, diff;
    logic [NUM_W-1:0] quo_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q, done_q, ge;
    logic [DEN_W:0]   trial;

    always_comb begin
        trial = {rem_q, quo_q[NUM_W-1]};
        ge    = trial >= {1'b0, den_q};
        diff  = trial[DEN_W-1:0] - den_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                rem_q  <= '0;
                quo_q  <= NUM_W'(NUMERATOR);
                den_q  <= den_i;
                cnt_q  <= CNT_W'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= ge ? diff : trial[DEN_W-1:0];
                quo_q <= {quo_q[NUM_W-2:0], ge};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign quo_o  = quo_q;

    // R3: quotient and remainder reproduce the numerator exactly
    a_r3_div_exact: assert property (@(posedge clk) disable iff (rst)
        (done_q && den_q != '0) |->
            (32'(quo_q) * 32'(den_q) + 32'(rem_q) == 32'(NUMERATOR)) && (rem_q < den_q));

    a_r3_no_restart: assert property (@(posedge clk) disable iff (rst)
        start_i |-> !busy_q);
endmodule

// File: rtl/cas_resolve.sv
module cas_resolve
    import cas_sel_pkg::*;
(
    input  logic [MAP_W-1:0]  map0_i,
    input  logic [MAP_W-1:0]  map1_i,
    input  logic [1:0]        sh0_i,
    input  logic [1:0]        sh1_i,
    output logic [CODE_W-1:0] code_o,
    output logic              err_o
);
    logic [1:0][MAP_W-1:0] raw;
    logic [1:0][1:0]       shs;
    logic [1:0][MAP_W-1:0] narrowed;
    logic [MAP_W-1:0]      chosen;

    assign raw = {map1_i, map0_i};
    assign shs = {sh1_i, sh0_i};

    for (genvar g = 0; g < 2; g++) begin : g_slot
        assign narrowed[g] = trim_map(raw[g], shs[g]);
    end

    always_comb begin
        err_o = 1'b0;
        if (narrowed[0] == '0)      chosen = narrowed[1];
        else if (narrowed[1] == '0) chosen = narrowed[0];
        else begin
            chosen = narrowed[0] & narrowed[1];
            err_o  = (chosen == '0);
        end
        code_o = cas_code(lo_bit(chosen));
    end

    // R6: an incompatible pair always reports the null code
    always_comb begin
        a_r6_err_null: assert (!err_o || code_o == '0);
    end
endmodule

// File: rtl/cas_latency_sel.sv
module cas_latency_sel
    import cas_sel_pkg::*;
#(
    parameter int BUS_W = 10,
    parameter int QUO_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [7:0]       slot0_map_i,
    input  logic [7:0]       slot0_tck1_i,
    input  logic [7:0]       slot0_tck2_i,
    input  logic [7:0]       slot1_map_i,
    input  logic [7:0]       slot1_tck1_i,
    input  logic [7:0]       slot1_tck2_i,
    input  logic [BUS_W-1:0] bus_mhz_i,
    output logic             done_o,
    output logic             err_o,
    output logic [2:0]       lat_code_o
);
    seq_state_e       state_q;
    slot_cfg_t        cfg_q [2];
    logic [1:0]       shift_q [2];
    logic [BUS_W-1:0] bus_q;
    logic             sel_q, ph_q;
    logic [7:0]       cur_byte;
    logic             skip, div_start, div_done, pass;
    logic [QUO_W-1:0] quo;
    logic [2:0]       res_code;
    logic             res_err;

    always_comb begin
        cur_byte  = ph_q ? cfg_q[sel_q].tck2 : cfg_q[sel_q].tck1;
        skip      = (cfg_q[sel_q].map == 8'hFF) || (cur_byte == 8'h00);
        div_start = (state_q == ST_PREP) && !skip;
        pass      = quo >= QUO_W'(bus_q);
    end

    cas_divider #(.NUM_W(QUO_W), .DEN_W(8), .NUMERATOR(20000)) u_div (
        .clk     (clk),
        .rst     (rst),
        .start_i (div_start),
        .den_i   (tck_divisor(cur_byte)),
        .done_o  (div_done),
        .quo_o   (quo)
    );

    cas_resolve u_res (
        .map0_i (cfg_q[0].map),
        .map1_i (cfg_q[1].map),
        .sh0_i  (shift_q[0]),
        .sh1_i  (shift_q[1]),
        .code_o (res_code),
        .err_o  (res_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cfg_q[0]   <= '0;
            cfg_q[1]   <= '0;
            shift_q[0] <= '0;
            shift_q[1] <= '0;
            bus_q      <= '0;
            sel_q      <= 1'b0;
            ph_q       <= 1'b0;
            done_o     <= 1'b0;
            err_o      <= 1'b0;
            lat_code_o <= '0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: if (start_i) begin
                    cfg_q[0]   <= '{slot0_map_i, slot0_tck1_i, slot0_tck2_i};
                    cfg_q[1]   <= '{slot1_map_i, slot1_tck1_i, slot1_tck2_i};
                    bus_q      <= bus_mhz_i;
                    shift_q[0] <= '0;
                    shift_q[1] <= '0;
                    sel_q      <= 1'b0;
                    ph_q       <= 1'b0;
                    state_q    <= ST_PREP;
                end
                ST_PREP: begin
                    if (!skip)      state_q <= ST_WAIT;
                    else if (sel_q) state_q <= ST_FIN;
                    else begin
                        sel_q <= 1'b1;
                        ph_q  <= 1'b0;
                    end
                end
                ST_WAIT: if (div_done) begin
                    if (pass) shift_q[sel_q] <= ph_q ? 2'd2 : 2'd1;
                    if (pass && !ph_q) begin
                        ph_q    <= 1'b1;
                        state_q <= ST_PREP;
                    end else if (sel_q) begin
                        state_q <= ST_FIN;
                    end else begin
                        sel_q   <= 1'b1;
                        ph_q    <= 1'b0;
                        state_q <= ST_PREP;
                    end
                end
                default: begin
                    lat_code_o <= res_code;
                    err_o      <= res_err;
                    done_o     <= 1'b1;
                    state_q    <= ST_IDLE;
                end
            endcase
        end
    end

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r8_code_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(lat_code_o) |-> done_o);

    a_r8_err_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(err_o) |-> done_o);

    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(bus_q) && $stable(cfg_q[0]) && $stable(cfg_q[1]));

    a_r4_shift_order: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && div_done && ph_q && pass) |=> shift_q[$past(sel_q)] == 2'd2);
endmodule

// File: tb/cas_latency_sel_test.sv
module cas_latency_sel_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] m0 = '0, a0 = '0, b0 = '0, m1 = '0, a1 = '0, b1 = '0;
    logic [9:0] bus = '0;
    logic       done_o, err_o;
    logic [2:0] lat_code_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cas_latency_sel uut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .slot0_map_i(m0), .slot0_tck1_i(a0), .slot0_tck2_i(b0),
        .slot1_map_i(m1), .slot1_tck1_i(a1), .slot1_tck2_i(b1),
        .bus_mhz_i(bus), .done_o(done_o), .err_o(err_o), .lat_code_o(lat_code_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit tck_ok(input logic [7:0] t, input int spd);
        int d;
        if (t == 8'h00) return 1'b0;
        d = int'(t[7:4]) * 10 + int'(t[3:0]);
        return (20000 / d) >= spd;
    endfunction

    function automatic logic [7:0] ref_trim(input logic [7:0] m, input logic [7:0] t1,
                                            input logic [7:0] t2, input int spd);
        int s, h, amt;
        if (m == 8'hFF) return 8'h00;
        s = 0;
        if (tck_ok(t1, spd)) begin
            s = 1;
            if (tck_ok(t2, spd)) s = 2;
        end
        h = 0;
        for (int i = 0; i < 8; i++) if (m[i]) h = i;
        amt = (h >= s) ? h - s : 0;
        return m & 8'((9'h0FF << amt));
    endfunction

    task automatic ref_calc(output int code, output int err);
        logic [7:0] t0, t1, c;
        int idx;
        int tbl [8] = '{5, 5, 2, 6, 3, 7, 4, 0};
        t0 = ref_trim(m0, a0, b0, int'(bus));
        t1 = ref_trim(m1, a1, b1, int'(bus));
        err = 0;
        if (t0 == 0)      c = t1;
        else if (t1 == 0) c = t0;
        else begin
            c = t0 & t1;
            if (c == 0) err = 1;
        end
        idx = 7;
        for (int i = 7; i >= 0; i--) if (c[i]) idx = i;
        code = tbl[idx];
    endtask

    // drives one run; optional disturbing start mid-run (R9)
    task automatic run(input string req, input bit disturb);
        int exp_code, exp_err, waited;
        ref_calc(exp_code, exp_err);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (disturb) begin
            @(negedge clk);
            m0 = ~m0; m1 = 8'h01; a0 = 8'h11; bus = 10'd1;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        waited = 0;
        while (!done_o && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        check(done_o == 1'b1, {req, " R8 done seen"}, int'(done_o), 1);
        check(int'(lat_code_o) == exp_code, {req, " code"}, int'(lat_code_o), exp_code);
        check(int'(err_o) == exp_err, {req, " R6 err"}, int'(err_o), exp_err);
        @(negedge clk);
        check(done_o == 1'b0, {req, " R8 done single"}, int'(done_o), 0);
        check(int'(lat_code_o) == exp_code, {req, " R8 hold"}, int'(lat_code_o), exp_code);
    endtask

    task automatic set_in(input logic [7:0] x0, y0, z0, x1, y1, z1, input int spd);
        m0 = x0; a0 = y0; b0 = z0; m1 = x1; a1 = y1; b1 = z1; bus = 10'(spd);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0C45);
        repeat (3) @(negedge clk);
        // R1 reset values
        check(done_o == 0, "R1 done", int'(done_o), 0);
        check(err_o == 0, "R1 err", int'(err_o), 0);
        check(lat_code_o == 0, "R1 code", int'(lat_code_o), 0);
        rst = 1'b0;

        // R2/R7: both slots empty -> code 0, no error
        set_in(8'hFF, 8'h50, 8'h60, 8'hFF, 8'h50, 8'h60, 133);
        run("R2 R7 both empty", 1'b0);
        // R2/R4/R5: slot1 empty, slot0 steps down twice
        set_in(8'h1C, 8'h50, 8'h60, 8'hFF, 8'h00, 8'h00, 133);
        run("R2 R4 R5 slot1 empty", 1'b0);
        // R3: zero first byte blocks second byte
        set_in(8'h1C, 8'h00, 8'h60, 8'hFF, 8'h00, 8'h00, 133);
        run("R3 R4 zero first", 1'b0);
        // R3: too slow second byte (7.5 ns -> 266 MHz < 300)
        set_in(8'h3C, 8'h30, 8'h75, 8'hFF, 8'h00, 8'h00, 300);
        run("R3 slow second", 1'b0);
        // R6: no common latency
        set_in(8'h01, 8'h00, 8'h00, 8'h04, 8'h00, 8'h00, 100);
        run("R6 incompatible", 1'b0);
        // R5: h smaller than shift
        set_in(8'h01, 8'h10, 8'h10, 8'hFF, 8'h00, 8'h00, 50);
        run("R5 low msb", 1'b0);
        // R7: intersection of two slots
        set_in(8'h3C, 8'h50, 8'h60, 8'h70, 8'h50, 8'h00, 150);
        run("R7 intersect", 1'b0);
        // R9: start while busy ignored
        set_in(8'h1C, 8'h50, 8'h60, 8'h38, 8'h50, 8'h60, 133);
        run("R9 busy start", 1'b1);

        // random mix
        for (int k = 0; k < 300; k++) begin
            logic [7:0] r [6];
            for (int j = 0; j < 6; j++) begin
                r[j] = 8'($urandom);
                if (j % 3 == 0) begin
                    if ($urandom_range(0, 7) == 0) r[j] = 8'hFF;
                end else if ($urandom_range(0, 3) == 0) r[j] = 8'h00;
            end
            set_in(r[0], r[1], r[2], r[3], r[4], r[5], int'($urandom_range(50, 500)));
            run("R3 R4 R5 R6 R7 random", 1'b0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule